// File: doc/BRIEF.md
# Transmit Line Fault Monitor

This block supervises the transmit side of a ternary line driver and reports two fault conditions. The first is a short between the two line outputs, which the analog current limiter signals as a short-sense input. The second is an open line, seen as a long run of pulse periods in which no mark was sent. All timing is counted in pulse periods, which a strobe input marks. A pulse-sent indication and the short sense are sampled only on that strobe.

When a short lasts long enough, the block drives its driver output-enable low so the line outputs go to high impedance. It then runs a periodic retry: after a fixed number of pulse periods it enables the drivers again and samples the short sense on the next pulse period. The short may still be there, in which case the drivers go back to high impedance. If the short has gone, they stay enabled and the short status clears. A control input can disable the automatic tri-state, and in that case the short is only reported. A freeze control holds both status bits.

A sticky interrupt request flags every change of the short status and every rising edge of the open status. A one-cycle acknowledge clears it. Short monitoring is active only while the ternary interface is selected.

Top module: `tx_line_fault_mon`

## Requirements
- R1: The short status sets on the strobe that completes 3 consecutive strobed samples with short sense high. A strobe with short sense low restarts the count.
- R2: When a short is declared with auto-tristate enabled (auto_tri_dis = 0), drv_en goes low on the same clock edge. With auto_tri_dis = 1, drv_en stays high, the status stays set while strobed short sense stays high, and it clears on the first strobe with short sense low.
- R3: In high impedance, drv_en returns high on the 128th strobe. If short sense is high on the following strobe, drv_en goes low again for another 128 strobes and the status stays set.
- R4: If short sense is low on the strobe after the drivers are re-enabled, drv_en stays high and the short status clears.
- R5: Every change of the short status, set or clear, sets the interrupt request on the same edge.
- R6: The open status sets on the 32nd consecutive strobe with pulse_sent low. It clears on the first strobe with pulse_sent high.
- R7: A rising edge of the open status sets the interrupt request. A falling edge does not.
- R8: While freeze is high, the short and open status hold their values, although detection and the tri-state sequence carry on. On release, the status takes up the current condition on the next edge.
- R9: The interrupt request stays high until a cycle with irq_ack high. An event in the same cycle as the acknowledge leaves it high.
- R10: While ternary_sel is low, the short status reads 0 and drv_en reads 1. This holds even in the middle of a retry sequence.
- R11: A cycle with sync_clr high clears both status bits, both detection counters and the interrupt request, and enables the drivers.
- R12: Without the strobe, pulse_sent and short_sense have no effect. An unstrobed pulse does not restart the open count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear of counters, status and interrupt |
| period_stb | input | 1 | One-cycle strobe per pulse period |
| pulse_sent | input | 1 | A mark was transmitted in this pulse period |
| short_sense | input | 1 | Current limiter reports the line outputs shorted |
| ternary_sel | input | 1 | Ternary line interface active; enables short monitoring |
| auto_tri_dis | input | 1 | 1 disables the automatic tri-state on a short |
| freeze | input | 1 | Hold both status bits |
| irq_ack | input | 1 | Clear the pending interrupt request |
| drv_en | output | 1 | Line driver output-enable (0 = high impedance) |
| short_flag | output | 1 | Short status |
| open_flag | output | 1 | Open-line status |
| irq | output | 1 | Sticky interrupt request |

## Verification
The hardest condition to reach is a second pass through the retry loop: a re-enable check that finds the short still present, followed by a second check that finds it gone. Getting there takes hundreds of strobes in a fixed order. The bench counts each strobe from the declaration and checks drv_en after every one, so both 128-period windows are checked at every step. The acknowledge-against-event race is reached by leaving an interrupt pending across a pulse and 31 quiet periods, then asserting the acknowledge on the strobe that completes the open run.

// File: rtl/txlf_pkg.sv
package txlf_pkg;
  typedef enum logic [1:0] {
    SG_WATCH = 2'd0,
    SG_HELD  = 2'd1,
    SG_HIZ   = 2'd2,
    SG_CHECK = 2'd3
  } sg_state_e;
endpackage

// File: rtl/txlf_short_guard.sv
module txlf_short_guard
  import txlf_pkg::*;
#(
  parameter int SHORT_PULSES  = 3,
  parameter int RETRY_PERIODS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_clr,
  input  logic period_stb,
  input  logic short_sense,
  input  logic ternary_sel,
  input  logic auto_tri_dis,
  output logic drv_en,
  output logic short_raw_nxt
);
  localparam int RUN_W = $clog2(SHORT_PULSES + 1);
  localparam int RET_W = $clog2(RETRY_PERIODS);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(SHORT_PULSES - 1);
  localparam logic [RET_W-1:0] RET_LAST = RET_W'(RETRY_PERIODS - 1);

  sg_state_e        state_q, state_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [RET_W-1:0] ret_q, ret_d;

  // next-state
  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    ret_d   = ret_q;
    if (sync_clr || !ternary_sel) begin
      state_d = SG_WATCH;
      run_d   = '0;
      ret_d   = '0;
    end else if (period_stb) begin
      unique case (state_q)
        SG_WATCH: begin
          if (!short_sense) begin
            run_d = '0;
          end else if (run_q == RUN_LAST) begin
            run_d   = '0;
            ret_d   = '0;
            state_d = auto_tri_dis ? SG_HELD : SG_HIZ;
          end else begin
            run_d = run_q + 1'b1;
          end
        end
        SG_HELD: begin
          if (!short_sense) begin
            state_d = SG_WATCH;
          end else if (!auto_tri_dis) begin
            state_d = SG_HIZ;
            ret_d   = '0;
          end
        end
        SG_HIZ: begin
          if (ret_q == RET_LAST) begin
            state_d = SG_CHECK;
            ret_d   = '0;
          end else begin
            ret_d = ret_q + 1'b1;
          end
        end
        SG_CHECK: begin
          if (short_sense) begin
            state_d = SG_HIZ;
            ret_d   = '0;
          end else begin
            state_d = SG_WATCH;
          end
        end
        default: state_d = SG_WATCH;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SG_WATCH;
      run_q   <= '0;
      ret_q   <= '0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      ret_q   <= ret_d;
    end
  end

  assign drv_en        = (state_q != SG_HIZ);
  assign short_raw_nxt = (state_d != SG_WATCH);

  // R1: drivers only drop after a strobed short sample
  a_r1_fall_needs_sense: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_en) |-> $past(period_stb && short_sense && ternary_sel));

  // R3: high impedance persists between strobes
  a_r3_hiz_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_en && !period_stb && !sync_clr && ternary_sel) |=> !drv_en);
endmodule

// File: rtl/txlf_open_watch.sv
module txlf_open_watch #(
  parameter int OPEN_ZEROS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_clr,
  input  logic period_stb,
  input  logic pulse_sent,
  output logic open_raw_nxt
);
  localparam int CNT_W = $clog2(OPEN_ZEROS + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(OPEN_ZEROS);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (sync_clr) begin
      cnt_d = '0;
    end else if (period_stb) begin
      if (pulse_sent)           cnt_d = '0;
      else if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign open_raw_nxt = (cnt_d == CNT_TOP);

  // R12: the zero-run count moves only on a strobe or a clear
  a_r12_count_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_stb && !sync_clr) |=> $stable(cnt_q));
endmodule

// File: rtl/txlf_status.sv
module txlf_status (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_clr,
  input  logic freeze,
  input  logic ternary_sel,
  input  logic short_raw_nxt,
  input  logic open_raw_nxt,
  input  logic irq_ack,
  output logic short_flag,
  output logic open_flag,
  output logic irq
);
  logic short_d, open_d, irq_d, evt;

  always_comb begin
    if (sync_clr || !ternary_sel) short_d = 1'b0;
    else if (freeze)              short_d = short_flag;
    else                          short_d = short_raw_nxt;

    if (sync_clr)    open_d = 1'b0;
    else if (freeze) open_d = open_flag;
    else             open_d = open_raw_nxt;

    evt   = !sync_clr && ((short_d != short_flag) || (open_d && !open_flag));
    irq_d = !sync_clr && (evt || (irq && !irq_ack));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_flag <= 1'b0;
      open_flag  <= 1'b0;
      irq        <= 1'b0;
    end else begin
      short_flag <= short_d;
      open_flag  <= open_d;
      irq        <= irq_d;
    end
  end

  // R8: freeze holds both status bits
  a_r8_open_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !sync_clr) |=> $stable(open_flag));
  a_r8_short_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && ternary_sel && !sync_clr) |=> $stable(short_flag));

  // R5: every short status change shows up on irq
  a_r5_short_change_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(short_flag) && !$past(sync_clr)) |-> irq);

  // R9: irq only drops after an acknowledge or clear
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_ack || sync_clr));
endmodule

// File: rtl/tx_line_fault_mon.sv
module tx_line_fault_mon #(
  parameter int SHORT_PULSES  = 3,
  parameter int RETRY_PERIODS = 128,
  parameter int OPEN_ZEROS    = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_clr,
  input  logic period_stb,
  input  logic pulse_sent,
  input  logic short_sense,
  input  logic ternary_sel,
  input  logic auto_tri_dis,
  input  logic freeze,
  input  logic irq_ack,
  output logic drv_en,
  output logic short_flag,
  output logic open_flag,
  output logic irq
);
  logic short_raw_nxt, open_raw_nxt;

  txlf_short_guard #(
    .SHORT_PULSES (SHORT_PULSES),
    .RETRY_PERIODS(RETRY_PERIODS)
  ) u_short (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_clr     (sync_clr),
    .period_stb   (period_stb),
    .short_sense  (short_sense),
    .ternary_sel  (ternary_sel),
    .auto_tri_dis (auto_tri_dis),
    .drv_en       (drv_en),
    .short_raw_nxt(short_raw_nxt)
  );

  txlf_open_watch #(
    .OPEN_ZEROS(OPEN_ZEROS)
  ) u_open (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_clr    (sync_clr),
    .period_stb  (period_stb),
    .pulse_sent  (pulse_sent),
    .open_raw_nxt(open_raw_nxt)
  );

  txlf_status u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_clr     (sync_clr),
    .freeze       (freeze),
    .ternary_sel  (ternary_sel),
    .short_raw_nxt(short_raw_nxt),
    .open_raw_nxt (open_raw_nxt),
    .irq_ack      (irq_ack),
    .short_flag   (short_flag),
    .open_flag    (open_flag),
    .irq          (irq)
  );

  // R10: non-ternary mode forces drivers on and short status off
  a_r10_ternary_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ternary_sel |=> (!short_flag && drv_en));

  // R11: synchronous clear leaves a clean state
  a_r11_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (drv_en && !short_flag && !open_flag && !irq));
endmodule

// File: tb/test_tx_line_fault_mon.sv
module test_tx_line_fault_mon;
  logic clk = 1'b0;
  logic rst_n, sync_clr, period_stb, pulse_sent, short_sense;
  logic ternary_sel, auto_tri_dis, freeze, irq_ack;
  logic drv_en, short_flag, open_flag, irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  tx_line_fault_mon i_tx_line_fault_mon (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .period_stb(period_stb),
    .pulse_sent(pulse_sent), .short_sense(short_sense), .ternary_sel(ternary_sel),
    .auto_tri_dis(auto_tri_dis), .freeze(freeze), .irq_ack(irq_ack),
    .drv_en(drv_en), .short_flag(short_flag), .open_flag(open_flag), .irq(irq)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // one pulse period, starting and ending at a falling edge
  task automatic strobe(input logic p, input logic s);
    period_stb = 1'b1; pulse_sent = p; short_sense = s;
    @(negedge clk);
    period_stb = 1'b0;
  endtask

  task automatic clr();
    sync_clr = 1'b1; @(negedge clk); sync_clr = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; sync_clr = 1'b0; period_stb = 1'b0; pulse_sent = 1'b0;
    short_sense = 1'b0; ternary_sel = 1'b1; auto_tri_dis = 1'b0;
    freeze = 1'b0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(drv_en, 1'b1, "R11 reset drv_en");
    chk(short_flag, 1'b0, "R11 reset short");
    chk(open_flag, 1'b0, "R11 reset open");
    chk(irq, 1'b0, "R11 reset irq");
    rst_n = 1'b1;
    @(negedge clk);

    // R6/R7 sweep of zero-run lengths
    for (int n = 1; n <= 40; n++) begin
      strobe(1'b0, 1'b0);
      chk(open_flag, (n >= 32), "R6 open after n zeros");
      chk(irq, (n >= 32), "R7 irq on open rise");
    end
    ack();
    strobe(1'b1, 1'b0);
    chk(open_flag, 1'b0, "R6 open clears on pulse");
    chk(irq, 1'b0, "R7 no irq on open fall");
    for (int n = 1; n <= 31; n++) strobe(1'b0, 1'b0);
    strobe(1'b1, 1'b0);
    chk(open_flag, 1'b0, "R6 31 zeros then pulse");

    // R12: unstrobed inputs ignored
    clr();
    pulse_sent = 1'b0; short_sense = 1'b1;
    repeat (50) @(negedge clk);
    chk(open_flag, 1'b0, "R12 no count without strobe");
    chk(short_flag, 1'b0, "R12 no short without strobe");
    for (int n = 1; n <= 31; n++) strobe(1'b0, 1'b0);
    pulse_sent = 1'b1;
    repeat (10) @(negedge clk);
    strobe(1'b0, 1'b0);
    chk(open_flag, 1'b1, "R12 unstrobed pulse ignored");

    // R1/R2/R5 sweep of short-run lengths
    for (int k = 1; k <= 5; k++) begin
      clr();
      for (int i = 1; i <= k; i++) begin
        strobe(1'b1, 1'b1);
        chk(short_flag, (i >= 3), "R1 short after 3 samples");
        chk(drv_en, (i < 3), "R2 tri-state on declare");
        chk(irq, (i >= 3), "R5 irq on short set");
      end
    end
    clr();
    strobe(1'b1, 1'b1); strobe(1'b1, 1'b1); strobe(1'b1, 1'b0);
    strobe(1'b1, 1'b1); strobe(1'b1, 1'b1);
    chk(short_flag, 1'b0, "R1 run restarts on clean sample");

    // R3/R4/R5 retry loop, two passes
    clr();
    repeat (3) strobe(1'b1, 1'b1);
    ack();
    for (int j = 1; j <= 128; j++) begin
      strobe(1'b1, 1'b1);
      chk(drv_en, (j == 128), "R3 retry window pass 1");
    end
    strobe(1'b1, 1'b1);
    chk(drv_en, 1'b0, "R3 still shorted back to hiz");
    chk(short_flag, 1'b1, "R3 status kept");
    chk(irq, 1'b0, "R5 no change no irq");
    for (int j = 1; j <= 128; j++) begin
      strobe(1'b1, 1'b1);
      chk(drv_en, (j == 128), "R3 retry window pass 2");
    end
    strobe(1'b1, 1'b0);
    chk(drv_en, 1'b1, "R4 drivers stay on");
    chk(short_flag, 1'b0, "R4 short clears");
    chk(irq, 1'b1, "R5 irq on short clear");

    // R2 auto tri-state disabled
    clr();
    auto_tri_dis = 1'b1;
    repeat (3) strobe(1'b1, 1'b1);
    chk(short_flag, 1'b1, "R2 report only set");
    ack();
    repeat (5) strobe(1'b1, 1'b1);
    chk(drv_en, 1'b1, "R2 drivers never off");
    chk(short_flag, 1'b1, "R2 status held with sense");
    strobe(1'b1, 1'b0);
    chk(short_flag, 1'b0, "R2 clears on clean sample");
    chk(irq, 1'b1, "R5 irq on clear in report mode");
    auto_tri_dis = 1'b0;

    // R8 freeze
    clr();
    freeze = 1'b1;
    repeat (3) strobe(1'b1, 1'b1);
    chk(short_flag, 1'b0, "R8 short frozen");
    chk(drv_en, 1'b0, "R8 tri-state runs under freeze");
    freeze = 1'b0; @(negedge clk);
    chk(short_flag, 1'b1, "R8 short after release");
    clr();
    freeze = 1'b1;
    repeat (32) strobe(1'b0, 1'b0);
    chk(open_flag, 1'b0, "R8 open frozen");
    chk(irq, 1'b0, "R8 no irq while frozen");
    freeze = 1'b0; @(negedge clk);
    chk(open_flag, 1'b1, "R8 open after release");
    chk(irq, 1'b1, "R7 irq on delayed rise");

    // R9 sticky irq and ack race
    clr();
    repeat (32) strobe(1'b0, 1'b0);
    strobe(1'b1, 1'b0);
    chk(irq, 1'b1, "R9 irq sticky");
    for (int n = 1; n <= 31; n++) strobe(1'b0, 1'b0);
    irq_ack = 1'b1;
    strobe(1'b0, 1'b0);
    irq_ack = 1'b0;
    chk(irq, 1'b1, "R9 event wins over ack");
    ack();
    chk(irq, 1'b0, "R9 ack clears");

    // R10 ternary off
    clr();
    ternary_sel = 1'b0;
    repeat (5) strobe(1'b1, 1'b1);
    chk(short_flag, 1'b0, "R10 no short when off");
    chk(drv_en, 1'b1, "R10 drivers on when off");
    ternary_sel = 1'b1;
    repeat (3) strobe(1'b1, 1'b1);
    chk(drv_en, 1'b0, "R10 hiz when on");
    ternary_sel = 1'b0; @(negedge clk);
    chk(drv_en, 1'b1, "R10 drop mid retry drv_en");
    chk(short_flag, 1'b0, "R10 drop mid retry short");
    ternary_sel = 1'b1;

    // R11 synchronous clear
    clr();
    repeat (32) strobe(1'b0, 1'b1);
    chk(open_flag, 1'b1, "R11 setup open");
    clr();
    chk(drv_en, 1'b1, "R11 clear drv_en");
    chk(short_flag, 1'b0, "R11 clear short");
    chk(open_flag, 1'b0, "R11 clear open");
    chk(irq, 1'b0, "R11 clear irq");

    finish_up();
  end
endmodule